// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a one-shot countdown timer meant to sit beside a local interrupt controller. Software programs a divide ratio through a small configuration register and then starts a countdown by writing a 32-bit start value. The countdown moves one step each time a prescaler completes a full divided period of the input clock. When the last step is taken, the block raises a timeout strobe for a single clock and then goes idle.

A current-count register can be read at any time. While the timer runs it reports how many divided periods remain, rounded up. When the timer is idle it reads zero. A new start value can be written at any moment. That write abandons whatever countdown was in flight and restarts the prescaler phase. The divide code uses a scrambled three-bit exponent field that is rotated by one. Because of this, the all-ones code selects division by one.

All register accesses use a plain write strobe and a plain read strobe. Each strobe has its own two-bit address. Read data is registered and arrives one cycle after the read strobe.

Top module: `dctimer`

## Requirements
- R1: The divide exponent is {cfg[3], cfg[1:0]} plus one, modulo 8, and the ratio D is 2 to that power. Cfg code 0x0 gives D=2, 0x3 gives D=16, 0x8 gives D=32, and 0xB gives D=1.
- R2: Register addresses are 0 for the start value, 1 for the current count and 2 for the divide configuration; address 3 reads zero. A configuration write keeps only wr_data & 0xB, so bit 2 always reads 0. Address 0 reads back the last start value written.
- R3: A write of a nonzero value N to address 0 on clock edge E makes tmo_pulse high in the cycle after edge E + N*D, and never earlier.
- R4: tmo_pulse is high for exactly one cycle. After it, the timer is idle and the current count reads 0.
- R5: Writing 0 to address 0 starts no countdown, stops any running one, and produces no timeout pulse.
- R6: Writing address 0 while a countdown runs abandons it, and the new countdown is timed from that write. If the write lands on the same edge as the expiry, the write wins and that expiry produces no pulse.
- R7: rd_data is updated on the edge that samples rd_en and reflects the state before that edge. For address 1, a running timer returns ceil(remaining input-clock periods / D).
- R8: The current count reads 0 when no countdown is active. Writes to address 1 change neither the countdown nor any register.
- R9: A divide change during a countdown takes effect at the next prescaler boundary. Steps already counted are not rescaled.
- R10: After synchronous reset, tmo_pulse is 0 and all addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| tmo_pulse | output | 1 | One-cycle timeout strobe |

## Verification
A restart write and the natural expiry can fall on the same clock edge. The bench provokes this with a one-step countdown at divide-by-one, followed by a second start write that the DUT samples on the expiry edge. The case is judged as passing when no pulse appears at the old expiry time and exactly one pulse appears the new count of periods later. A divide change that arrives on the edge just before a prescaler boundary is used in the same way. Its expected pulse cycle is worked out step by step, with the old phase finishing and the new ratio applying from the boundary on.

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;
  localparam int CFG_W  = 4;
  localparam int EXP_W  = 3;
  localparam int ADDR_W = 2;
  localparam logic [CFG_W-1:0] CFG_KEEP = 4'b1011;

  typedef enum logic [ADDR_W-1:0] {
    RA_START = 2'd0,
    RA_CUR   = 2'd1,
    RA_CFG   = 2'd2,
    RA_RSV   = 2'd3
  } reg_addr_e;

  // scrambled exponent: bit 3 on top of bits 1:0, rotated by one (wraps mod 8)
  function automatic logic [EXP_W-1:0] cfg_to_exp(input logic [CFG_W-1:0] cfg);
    return {cfg[3], cfg[1:0]} + 3'd1;
  endfunction
endpackage

// File: rtl/dctimer_divdec.sv
module dctimer_divdec
  import dctimer_pkg::*;
#(
  parameter int PRE_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  output logic [PRE_W-1:0] ratio_m1
);
  localparam int NUM_EXP = 1 << EXP_W;

  logic [PRE_W-1:0] ratio_lut [NUM_EXP];

  genvar g;
  for (g = 0; g < NUM_EXP; g++) begin : g_lut
    assign ratio_lut[g] = PRE_W'((64'd1 << g) - 64'd1);
  end

  assign ratio_m1 = ratio_lut[cfg_to_exp(cfg)];

  AST_RATIO_POW2: assert property (@(posedge clk) disable iff (rst)
    $onehot({1'b0, ratio_m1} + 1'b1)); // R1
endmodule

// File: rtl/dctimer_prescale.sv
module dctimer_prescale #(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             active,
  input  logic [PRE_W-1:0] ratio_m1,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (start) begin
      pre_q <= ratio_m1;
    end else if (active) begin
      if (pre_q == '0) pre_q <= ratio_m1;
      else             pre_q <= pre_q - 1'b1;
    end
  end

  assign tick = active && !start && (pre_q == '0);

  AST_PRE_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && !start && pre_q != '0) |=> pre_q == $past(pre_q) - 1'b1); // R3
  AST_PRE_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (active && !start && pre_q == '0) |=> pre_q == $past(ratio_m1)); // R9
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
    start |=> pre_q == $past(ratio_m1)); // R6
endmodule

// File: rtl/dctimer_count.sv
module dctimer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic             tick,
  output logic             active,
  output logic [CNT_W-1:0] remain,
  output logic             tmo
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      active <= 1'b0;
      tmo    <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (start) begin
        remain <= start_val;
        active <= |start_val;
      end else if (tick) begin
        remain <= remain - 1'b1;
        if (remain == LAST) begin
          active <= 1'b0;
          tmo    <= 1'b1;
        end
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    tmo |=> !tmo); // R4
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tmo |-> (!active && $past(remain) == LAST)); // R3
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !active |-> remain == '0); // R4
  AST_ZERO_NOSTART: assert property (@(posedge clk) disable iff (rst)
    (start && start_val == '0) |=> (!active && !tmo)); // R5
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    start |=> !tmo); // R6
endmodule

// File: rtl/dctimer_regs.sv
module dctimer_regs
  import dctimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              active,
  input  logic [CNT_W-1:0]  remain,
  output logic [CFG_W-1:0]  cfg,
  output logic              start,
  output logic [CNT_W-1:0]  start_val,
  output logic [CNT_W-1:0]  rd_data
);
  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] start_q;

  assign start     = wr_en && (wr_addr == RA_START);
  assign start_val = wr_data;
  assign cfg       = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      start_q <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && wr_addr == RA_CFG) cfg_q <= wr_data[CFG_W-1:0] & CFG_KEEP;
      if (start) start_q <= wr_data;
      if (rd_en) begin
        case (reg_addr_e'(rd_addr))
          RA_START: rd_data <= start_q;
          RA_CUR:   rd_data <= active ? remain : '0;
          RA_CFG:   rd_data <= CNT_W'(cfg_q);
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  AST_CFG_BIT2_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == RA_CFG) |=> rd_data[2] == 1'b0); // R2
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == RA_CUR && !active) |=> rd_data == '0); // R8
  AST_CUR_RO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == RA_CUR) |=> (cfg_q == $past(cfg_q) && start_q == $past(start_q))); // R8
endmodule

// File: rtl/dctimer.sv
module dctimer
  import dctimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              tmo_pulse
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [CFG_W-1:0] cfg;
  logic             start;
  logic [CNT_W-1:0] start_val;
  logic [PRE_W-1:0] ratio_m1;
  logic             tick;
  logic             active;
  logic [CNT_W-1:0] remain;

  dctimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .active(active), .remain(remain),
    .cfg(cfg), .start(start), .start_val(start_val),
    .rd_data(rd_data)
  );

  dctimer_divdec #(.PRE_W(PRE_W)) u_divdec (
    .clk(clk), .rst(rst), .cfg(cfg), .ratio_m1(ratio_m1)
  );

  dctimer_prescale #(.PRE_W(PRE_W)) u_prescale (
    .clk(clk), .rst(rst), .start(start), .active(active),
    .ratio_m1(ratio_m1), .tick(tick)
  );

  dctimer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .start(start), .start_val(start_val),
    .tick(tick), .active(active), .remain(remain), .tmo(tmo_pulse)
  );
endmodule

// File: tb/dctimer_tb.sv
`timescale 1ns/1ps
module dctimer_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        tmo;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dctimer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tmo_pulse(tmo)
  );

  function automatic int ratio_of(input logic [3:0] cfg);
    int e;
    e = ({29'd0, cfg[3], cfg[1:0]} + 1) % 8;
    return 1 << e;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // starts a countdown; j counts edges after the start write edge
  task automatic run_timer(input string tag, input logic [3:0] cfg, input int n,
                           input int rd_at, input int exp_rd,
                           input int poke_at, input logic [1:0] poke_addr,
                           input logic [31:0] poke_data,
                           input int exp_at, input int lim);
    int seen_at = -1;
    int pulses  = 0;
    bus_write(2'd2, {28'd0, cfg});
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = n;
    @(negedge clk);
    for (int j = 0; j <= lim; j++) begin
      if (rd_at >= 0 && j == rd_at + 1)
        check32({tag, " current count"}, rd_data, exp_rd);
      if (tmo === 1'b1) begin
        pulses++;
        if (seen_at < 0) seen_at = j;
      end
      wr_en = (j == poke_at); wr_addr = poke_addr; wr_data = poke_data;
      rd_en = (j == rd_at);   rd_addr = 2'd1;
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    n_tests++;
    if (pulses != ((exp_at >= 0) ? 1 : 0) || seen_at != exp_at) begin
      n_fail++;
      $display("FAIL %s pulse: actual at %0d (count %0d) expected at %0d",
               tag, seen_at, pulses, exp_at);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check32("R10 pulse", {31'd0, tmo}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], v);
      check32("R10 readback", v, 32'd0);
    end

    // R2: configuration mask and reserved address
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, v);
    check32("R2 cfg mask", v, 32'h0000_000B);
    bus_write(2'd2, 32'h0000_0004);
    bus_read(2'd2, v);
    check32("R2 cfg bit2", v, 32'd0);
    bus_read(2'd3, v);
    check32("R2 reserved", v, 32'd0);

    // R1: every exponent code, bit 2 set as junk
    for (int e = 0; e < 8; e++) begin
      logic [3:0] c;
      int d;
      c = {e[2], 1'b1, e[1:0]};
      d = ratio_of(c);
      run_timer("R1 decode", c, 2, d, 1, -1, 2'd0, 32'd0, 2 * d, 2 * d + 2);
    end

    // R3/R4: divide by one, one step; read after expiry gives 0
    run_timer("R4 one step", 4'hB, 1, 1, 0, -1, 2'd0, 32'd0, 1, 4);

    // R5: zero start value, and zero written mid-run
    run_timer("R5 zero", 4'hB, 0, 3, 0, -1, 2'd0, 32'd0, -1, 40);
    run_timer("R5 stop", 4'hB, 10, 5, 0, 2, 2'd0, 32'd0, -1, 20);

    // R6: restart mid-run (D=2, N=5, restart with 2 sampled on edge 4)
    run_timer("R6 restart", 4'h0, 5, 5, 2, 3, 2'd0, 32'd2, 8, 12);
    // R6: restart on the expiry edge wins
    run_timer("R6 same edge", 4'hB, 1, 2, 2, 0, 2'd0, 32'd3, 4, 7);
    bus_read(2'd0, v);
    check32("R2 start readback", v, 32'd3);

    // R9: divide change mid-run, old phase finishes then new ratio applies
    run_timer("R9 div change", 4'h0, 3, 2, 2, 0, 2'd2, 32'h0000_000B, 4, 7);

    // R8: writes to current count ignored while running and idle
    run_timer("R8 ro running", 4'hB, 6, 3, 3, 1, 2'd1, 32'd0, 6, 9);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, v);
    check32("R8 ro idle", v, 32'd0);
    bus_read(2'd0, v);
    check32("R8 start untouched", v, 32'd6);

    // R3/R7: random ratio, count and read point
    for (int i = 0; i < 20; i++) begin
      logic [3:0] c;
      int d, n, nt, ra, er;
      c  = 4'($urandom % 16);
      d  = ratio_of(c);
      n  = 1 + int'($urandom % 20);
      nt = n * d;
      ra = int'($urandom % (nt + 2));
      er = (ra < nt) ? (nt - ra + d - 1) / d : 0;
      run_timer("R7 random", c, n, ra, er, -1, 2'd0, 32'd0, nt, nt + 2);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule